// File: doc/BRIEF.md
# Linked-List Descriptor Loader

This block sequences transfers for a set of DMA channels. Each channel keeps eight 32-bit working registers. An in-memory descriptor is an image of those same eight registers. Software gives a channel the address of the first descriptor and sets the list-enable bit. The channel then reads the descriptor into its working registers one word at a time and hands the transfer it describes to a data mover. When the mover reports the transfer finished, the channel follows the node address that it just loaded.

A node address of zero ends the chain. A chain whose last node points back at its head repeats until software cancels it. Every channel sends single-cycle event pulses to an external counter block. The first pulse of a list means the list has been loaded, and each later pulse means one descriptor's transfer has finished. All channels share a single descriptor read port, and a fixed-priority arbiter decides which channel uses it.

Top module: `lldma_loader`

## Requirements
- R1: After reset every working register reads zero, the active-size register reads 0x00FFFFFF, and `mem_req_o`, `mv_start_o` and `evt_o` are low.
- R2: Channel c's registers are at byte address c*0x40 plus a word offset. Offsets 0x00 to 0x1C read back what was written. Offset 0x30 is read-only. Writes to 0x30, and writes whose two low address bits are not zero, change nothing.
- R3: A write to the control word (offset 0x1C) with bit 4 set and bit 20 clear, while the channel is idle, starts a fetch from the address held at offset 0x14. Word k is read from that address + 4k in increasing k, and each word is loaded into the register at offset 4k.
- R4: `mv_start_o` pulses for exactly one cycle, in the cycle after the eighth word is accepted and never earlier. At that point `mv_rd_addr_o`, `mv_wr_addr_o` and `mv_len_o` carry words 0x08, 0x0C and bits 23:0 of word 0x10.
- R5: The first event pulse of a list appears in the same cycle as the first `mv_start_o`, before any transfer completes. Every `mv_done_i` gives one event pulse in the following cycle.
- R6: When a transfer completes and its loaded node address is zero, the channel goes idle, starts nothing more, and bit 4 of its control word reads 0.
- R7: When a transfer completes and its node address is non-zero, the next fetch starts at that address. A chain that points back to its head keeps alternating through its descriptors.
- R8: Offset 0x30 reads bits 23:0 of word 0x10 (the byte count minus one), zero-extended, from the start pulse until the done is accepted. At all other times it reads 0x00FFFFFF.
- R9: A write to the control word with bit 20 set makes the channel idle at the next edge. The write overrides a word delivery or a `mv_done_i` in the same cycle, so no event pulse and no further fetch or start follow it. The stored control word has bits 0, 4 and 20 cleared.
- R10: Among channels fetching at the same time, the lowest-numbered channel owns the read port. A request that has not been acknowledged stays up with its address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | $clog2(NUM_CH)+6 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Descriptor word byte address |
| mem_ack_i | input | 1 | Word delivered this cycle |
| mem_rdata_i | input | 32 | Delivered descriptor word |
| mv_start_o | output | NUM_CH | Per-channel transfer start pulse |
| mv_done_i | input | NUM_CH | Per-channel transfer done pulse |
| mv_rd_addr_o | output | NUM_CH x 32 | Source address of each channel's transfer |
| mv_wr_addr_o | output | NUM_CH x 32 | Destination address of each channel's transfer |
| mv_len_o | output | NUM_CH x 24 | Byte count minus one of each transfer |
| evt_o | output | NUM_CH | Per-channel completion event pulse |

## Verification
Two functions can coincide in one cycle: the start of one channel's fetch and the fetch already running on another channel. The bench starts channel 1, then starts channel 0 one cycle later, so that channel 0 takes the read port away from channel 1 after channel 1's first word. The logged sequence of word addresses must show channel 1's first word, then all eight of channel 0's words, then channel 1's remaining seven. A second collision is a cancel written in the same cycle as a word delivery. After that cancel, no start and no event may follow.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned LEN_W      = 24;

  // word indices inside a channel window
  localparam logic [3:0] IDX_RADDR = 4'd2;
  localparam logic [3:0] IDX_WADDR = 4'd3;
  localparam logic [3:0] IDX_SIZE  = 4'd4;
  localparam logic [3:0] IDX_NODE  = 4'd5;
  localparam logic [3:0] IDX_CTRL  = 4'd7;
  localparam logic [3:0] IDX_ACT   = 4'd12;

  localparam int unsigned CTRL_EN     = 0;
  localparam int unsigned CTRL_LIST   = 4;
  localparam int unsigned CTRL_CANCEL = 20;

  typedef enum logic [1:0] {
    CH_IDLE,
    CH_FETCH,
    CH_KICK,
    CH_WAIT
  } ch_state_e;
endpackage

// File: rtl/lldma_arb.sv
module lldma_arb #(
  parameter int N  = 2,
  parameter int AW = 32
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][AW-1:0] addr_i,
  output logic [N-1:0]         gnt_o,
  output logic [AW-1:0]        addr_o
);
  // lowest index wins
  always_comb begin
    gnt_o  = '0;
    addr_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o  = '0;
        gnt_o[i] = 1'b1;
        addr_o = addr_i[i];
      end
    end
  end
endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [3:0]        rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              req_o,
  output logic [WORD_W-1:0] addr_o,
  input  logic              ack_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              start_o,
  input  logic              done_i,
  output logic              evt_o,
  output logic [WORD_W-1:0] rd_addr_o,
  output logic [WORD_W-1:0] wr_addr_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [WORD_W-1:0] CLR_MASK =
    ~((WORD_W'(1) << CTRL_CANCEL) | (WORD_W'(1) << CTRL_LIST) | (WORD_W'(1) << CTRL_EN));

  logic [DESC_WORDS-1:0][WORD_W-1:0] regs_q;
  ch_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] ptr_q;
  logic              first_q, evt_q;
  logic              is_ctrl, cancel, launch, in_xfer;
  logic [WORD_W-1:0] act_size;

  assign is_ctrl = wr_i && (wr_idx_i == IDX_CTRL);
  assign cancel  = is_ctrl && wr_data_i[CTRL_CANCEL];
  assign launch  = is_ctrl && wr_data_i[CTRL_LIST] && !wr_data_i[CTRL_CANCEL]
                   && (state_q == CH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q  <= '0;
      state_q <= CH_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (wr_i && !wr_idx_i[3])
        regs_q[wr_idx_i[IDX_W-1:0]] <= cancel ? (wr_data_i & CLR_MASK) : wr_data_i;
      if (cancel) begin
        state_q <= CH_IDLE;
      end else begin
        unique case (state_q)
          CH_IDLE: if (launch) begin
            ptr_q   <= regs_q[IDX_NODE[IDX_W-1:0]];
            idx_q   <= '0;
            first_q <= 1'b1;
            state_q <= CH_FETCH;
          end
          CH_FETCH: if (ack_i) begin
            regs_q[idx_q] <= word_i;
            if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
              evt_q   <= first_q;
              first_q <= 1'b0;
              state_q <= CH_KICK;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
          CH_KICK: state_q <= CH_WAIT;
          CH_WAIT: if (done_i) begin
            evt_q <= 1'b1;
            if (regs_q[IDX_NODE[IDX_W-1:0]] == '0) begin
              regs_q[IDX_CTRL[IDX_W-1:0]][CTRL_LIST] <= 1'b0;
              state_q <= CH_IDLE;
            end else begin
              ptr_q   <= regs_q[IDX_NODE[IDX_W-1:0]];
              idx_q   <= '0;
              state_q <= CH_FETCH;
            end
          end
          default: state_q <= CH_IDLE;
        endcase
      end
    end
  end

  assign in_xfer  = (state_q == CH_KICK) || (state_q == CH_WAIT);
  assign act_size = in_xfer ? {{(WORD_W-LEN_W){1'b0}}, regs_q[IDX_SIZE[IDX_W-1:0]][LEN_W-1:0]}
                            : {{(WORD_W-LEN_W){1'b0}}, {LEN_W{1'b1}}};

  always_comb begin
    if (!rd_idx_i[3])           rd_data_o = regs_q[rd_idx_i[IDX_W-1:0]];
    else if (rd_idx_i == IDX_ACT) rd_data_o = act_size;
    else                        rd_data_o = '0;
  end

  assign req_o     = (state_q == CH_FETCH);
  assign addr_o    = ptr_q + {{(WORD_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
  assign start_o   = (state_q == CH_KICK);
  assign evt_o     = evt_q;
  assign rd_addr_o = regs_q[IDX_RADDR[IDX_W-1:0]];
  assign wr_addr_o = regs_q[IDX_WADDR[IDX_W-1:0]];
  assign len_o     = regs_q[IDX_SIZE[IDX_W-1:0]][LEN_W-1:0];
endmodule

// File: rtl/lldma_loader.sv
module lldma_loader
  import lldma_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_wr_i,
  input  logic [$clog2(NUM_CH)+5:0]    reg_addr_i,
  input  logic [31:0]                  reg_wdata_i,
  output logic [31:0]                  reg_rdata_o,
  output logic                         mem_req_o,
  output logic [31:0]                  mem_addr_o,
  input  logic                         mem_ack_i,
  input  logic [31:0]                  mem_rdata_i,
  output logic [NUM_CH-1:0]            mv_start_o,
  input  logic [NUM_CH-1:0]            mv_done_i,
  output logic [NUM_CH-1:0][31:0]      mv_rd_addr_o,
  output logic [NUM_CH-1:0][31:0]      mv_wr_addr_o,
  output logic [NUM_CH-1:0][23:0]      mv_len_o,
  output logic [NUM_CH-1:0]            evt_o
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int RA_W = CH_W + 6;

  logic [CH_W-1:0]                sel_ch;
  logic [3:0]                     off_idx;
  logic                           aligned;
  logic [NUM_CH-1:0]              chan_req, chan_gnt, chan_ack;
  logic [NUM_CH-1:0][WORD_W-1:0]  chan_addr, chan_rd;

  assign sel_ch   = reg_addr_i[RA_W-1:6];
  assign off_idx  = reg_addr_i[5:2];
  assign aligned  = (reg_addr_i[1:0] == 2'b00);
  assign chan_ack = chan_gnt & {NUM_CH{mem_ack_i}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lldma_chan i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_wr_i && aligned && (sel_ch == CH_W'(c))),
      .wr_idx_i  (off_idx),
      .wr_data_i (reg_wdata_i),
      .rd_idx_i  (off_idx),
      .rd_data_o (chan_rd[c]),
      .req_o     (chan_req[c]),
      .addr_o    (chan_addr[c]),
      .ack_i     (chan_ack[c]),
      .word_i    (mem_rdata_i),
      .start_o   (mv_start_o[c]),
      .done_i    (mv_done_i[c]),
      .evt_o     (evt_o[c]),
      .rd_addr_o (mv_rd_addr_o[c]),
      .wr_addr_o (mv_wr_addr_o[c]),
      .len_o     (mv_len_o[c])
    );
  end

  lldma_arb #(.N(NUM_CH), .AW(WORD_W)) i_arb (
    .req_i  (chan_req),
    .addr_i (chan_addr),
    .gnt_o  (chan_gnt),
    .addr_o (mem_addr_o)
  );

  assign mem_req_o = |chan_req;

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (aligned && sel_ch == CH_W'(c)) reg_rdata_o = chan_rd[c];
  end
endmodule

// File: rtl/lldma_checker.sv
module lldma_checker #(
  parameter int NUM_CH = 2,
  parameter int RA_W   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [RA_W-1:0]   reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [31:0]       mem_addr_o,
  input logic [NUM_CH-1:0] mv_start_o,
  input logic [NUM_CH-1:0] evt_o,
  input logic [NUM_CH-1:0] chan_req,
  input logic [NUM_CH-1:0] chan_gnt
);
  a_r10_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_gnt));

  a_r10_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !reg_wr_i) |=> (mem_req_o && $stable(mem_addr_o)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r10_gnt_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chan_gnt[c] |-> chan_req[c]);

    a_r4_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mv_start_o[c] |=> !mv_start_o[c]);

    a_r4_start_after_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mv_start_o[c]) |-> $past(chan_gnt[c] && mem_ack_i));

    a_r5_evt_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o[c] |=> !evt_o[c]);

    a_r9_cancel_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_addr_i == RA_W'(c * 64 + 28) && reg_wdata_i[20])
        |=> (!chan_req[c] && !mv_start_o[c] && !evt_o[c]));
  end
endmodule

bind lldma_loader lldma_checker #(.NUM_CH(NUM_CH), .RA_W(RA_W)) i_lldma_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .mem_req_o   (mem_req_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mv_start_o  (mv_start_o),
  .evt_o       (evt_o),
  .chan_req    (chan_req),
  .chan_gnt    (chan_gnt)
);

// File: tb/test_lldma_loader.sv
module test_lldma_loader;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [6:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             mem_req, mem_ack;
  logic [31:0]      mem_addr, mem_rdata;
  logic [1:0]       mv_start, evt;
  logic [1:0]       mv_done = '0;
  logic [1:0][31:0] mv_rd, mv_wr;
  logic [1:0][23:0] mv_len;

  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[7:2]];
  assign mem_ack   = mem_req;

  int n_chk = 0, n_bad = 0;
  int fcnt = 0;
  logic [31:0] flog [32];
  int scnt [2], ecnt [2], mcnt [2];
  logic [31:0] slog [2][16];
  logic [23:0] llog [2][16];
  int sfetch [2][16];
  logic sevt [2][16];
  logic hold [2];
  int dly = 3;

  always #(CLK_PERIOD/2) clk = ~clk;

  lldma_loader #(.NUM_CH(2)) i_lldma_loader (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .mv_start_o(mv_start), .mv_done_i(mv_done),
    .mv_rd_addr_o(mv_rd), .mv_wr_addr_o(mv_wr), .mv_len_o(mv_len), .evt_o(evt)
  );

  // monitor and mover stub, sampled 3 time units after the rising edge
  initial begin
    for (int c = 0; c < 2; c++) begin
      scnt[c] = 0; ecnt[c] = 0; mcnt[c] = 0; hold[c] = 1'b0;
    end
    forever begin
      @(posedge clk);
      #3;
      mv_done = '0;
      if (mem_req && mem_ack) begin
        if (fcnt < 32) flog[fcnt] = mem_addr;
        fcnt++;
      end
      for (int c = 0; c < 2; c++) begin
        if (evt[c]) ecnt[c]++;
        if (mv_start[c]) begin
          if (scnt[c] < 16) begin
            slog[c][scnt[c]]   = mv_rd[c];
            llog[c][scnt[c]]   = mv_len[c];
            sfetch[c][scnt[c]] = fcnt;
            sevt[c][scnt[c]]   = evt[c];
          end
          scnt[c]++;
          mcnt[c] = dly;
        end else if (mcnt[c] > 0 && !hold[c]) begin
          mcnt[c]--;
          if (mcnt[c] == 0) mv_done[c] = 1'b1;
        end
      end
    end
  end

  function automatic logic [6:0] ra(input int c, input logic [5:0] off);
    return {c[0], off};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_starts(input int c, input int n);
    for (int k = 0; k < 3000 && scnt[c] < n; k++) @(negedge clk);
  endtask

  task automatic wait_evts(input int c, input int n);
    for (int k = 0; k < 3000 && ecnt[c] < n; k++) @(negedge clk);
  endtask

  task automatic put_desc(input int base, input logic [31:0] ra_v, input logic [31:0] wa_v,
                          input logic [31:0] sz, input logic [31:0] node);
    mem[base/4 + 0] = 32'h0000_1011;
    mem[base/4 + 1] = 32'h0000_0FF0;
    mem[base/4 + 2] = ra_v;
    mem[base/4 + 3] = wa_v;
    mem[base/4 + 4] = sz;
    mem[base/4 + 5] = node;
    mem[base/4 + 6] = 32'h0;
    mem[base/4 + 7] = 32'h0000_0011;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(ra(0, 6'h14), v);  chk("R1 node reg", v, 32'h0);
    rd(ra(1, 6'h1C), v);  chk("R1 ctrl reg", v, 32'h0);
    rd(ra(0, 6'h30), v);  chk("R1 active size", v, 32'h00FF_FFFF);
    chk("R1 outputs idle", {29'h0, mem_req, |mv_start, |evt}, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(ra(1, 6'h08), 32'hABCD_1234);
    rd(ra(1, 6'h08), v);  chk("R2 readback ch1", v, 32'hABCD_1234);
    rd(ra(0, 6'h08), v);  chk("R2 ch0 untouched", v, 32'h0);
    wr(ra(1, 6'h30), 32'h5);
    rd(ra(1, 6'h30), v);  chk("R2 active read-only", v, 32'h00FF_FFFF);
    wr(ra(1, 6'h09), 32'hFFFF_FFFF);
    rd(ra(1, 6'h08), v);  chk("R2 misaligned ignored", v, 32'hABCD_1234);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    int bad;
    fcnt = 0;
    hold[0] = 1'b1;
    dly = 3;
    wr(ra(0, 6'h14), 32'h80);
    wr(ra(0, 6'h1C), 32'h11);
    wait_starts(0, 1);
    bad = 0;
    for (int k = 0; k < 8; k++) if (flog[k] !== 32'h80 + 32'(4*k)) bad++;
    chk("R3 fetch order", 32'(bad), 32'h0);
    chk("R4 eight words before start", 32'(sfetch[0][0]), 32'd8);
    chk("R4 source addr", slog[0][0], 32'h1000);
    chk("R4 length", {8'h0, llog[0][0]}, 32'h0F);
    chk("R5 loaded event with first start", {31'h0, sevt[0][0]}, 32'h1);
    chk("R5 one event before completion", 32'(ecnt[0]), 32'd1);
    rd(ra(0, 6'h08), v);  chk("R3 word loaded", v, 32'h1000);
    rd(ra(0, 6'h30), v);  chk("R8 active size in flight", v, 32'h0F);
    hold[0] = 1'b0;
    wait_starts(0, 2);
    chk("R5 completion event", 32'(ecnt[0]), 32'd2);
    chk("R7 next fetch addr", flog[8], 32'hA0);
    chk("R7 second transfer", slog[0][1], 32'h1100);
    wait_evts(0, 3);
    repeat (20) @(negedge clk);
    chk("R6 no start after last", 32'(scnt[0]), 32'd2);
    chk("R6 event count", 32'(ecnt[0]), 32'd3);
    rd(ra(0, 6'h1C), v);  chk("R6 list enable cleared", v & 32'h10, 32'h0);
    rd(ra(0, 6'h30), v);  chk("R8 active size idle", v, 32'h00FF_FFFF);
  endtask

  task automatic t_cyclic_cancel;
    logic [31:0] v;
    int s0, e0;
    dly = 2;
    wr(ra(1, 6'h14), 32'h40);
    wr(ra(1, 6'h1C), 32'h11);
    wait_starts(1, 4);
    chk("R7 cyclic 0", slog[1][0], 32'h3000);
    chk("R7 cyclic 1", slog[1][1], 32'h3100);
    chk("R7 cyclic 2", slog[1][2], 32'h3000);
    chk("R7 cyclic 3", slog[1][3], 32'h3100);
    chk("R5 events in cyclic", 32'(ecnt[1]), 32'd4);
    for (int k = 0; k < 3000 && !(mem_req && mem_addr[7:6] == 2'b01); k++) @(negedge clk);
    s0 = scnt[1];
    e0 = ecnt[1];
    wr(ra(1, 6'h1C), 32'h0010_0011);   // cancel in the same cycle as a word delivery
    chk("R9 request dropped", {31'h0, mem_req}, 32'h0);
    repeat (20) @(negedge clk);
    chk("R9 no further start", 32'(scnt[1]), 32'(s0));
    chk("R9 no further event", 32'(ecnt[1]), 32'(e0));
    rd(ra(1, 6'h1C), v);  chk("R9 ctrl bits cleared", v & 32'h0010_0011, 32'h0);
  endtask

  task automatic t_collide;
    int bad, e0, e1;
    dly = 3;
    e0 = ecnt[0];
    e1 = ecnt[1];
    wr(ra(0, 6'h14), 32'hA0);
    wr(ra(1, 6'h14), 32'hC0);
    fcnt = 0;
    wr(ra(1, 6'h1C), 32'h11);
    wr(ra(0, 6'h1C), 32'h11);
    wait_evts(0, e0 + 2);
    wait_evts(1, e1 + 2);
    bad = 0;
    if (flog[0] !== 32'hC0) bad++;
    for (int k = 1; k < 9; k++)  if (flog[k] !== 32'hA0 + 32'(4*(k-1))) bad++;
    for (int k = 9; k < 16; k++) if (flog[k] !== 32'hC4 + 32'(4*(k-9))) bad++;
    chk("R10 priority interleave", 32'(bad), 32'h0);
    chk("R10 total words", 32'(fcnt), 32'd16);
    chk("R10 ch0 transfer", slog[0][scnt[0]-1], 32'h1100);
    chk("R10 ch1 transfer", slog[1][scnt[1]-1], 32'h4000);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'h0;
    put_desc(32'h40, 32'h3000, 32'h5000, 32'h07, 32'h60);
    put_desc(32'h60, 32'h3100, 32'h5100, 32'h1F, 32'h40);
    put_desc(32'h80, 32'h1000, 32'h2000, 32'h0F, 32'hA0);
    put_desc(32'hA0, 32'h1100, 32'h2100, 32'h3F, 32'h0);
    put_desc(32'hC0, 32'h4000, 32'h6000, 32'h03, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_chain();
    t_cyclic_cancel();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule